// File: doc/BRIEF.md
# Parallel LCD Bus Job Controller

This block drives a parallel LCD panel bus of the 8080 kind. The bus has an active-low chip select, read strobe and write strobe, a register-select line and a 16-bit data path with an output enable. A register file hands the block one of three job kinds. The first is a generic command byte, optionally followed by parameter words that software streams in one trigger at a time. The second is a full-screen fill that writes one constant word to every pixel. The third is a frame refresh, whose pixel words come from a video backend through a request/ready handshake.

A built-in period timer can start refreshes by itself. With the sync option enabled, it can also hold each automatic refresh until the timer reaches a chosen point in its period. Every bus write is paced by a programmable divider. Single-cycle start and done pulses and a state code let the register file track progress.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are 1, `bus_doe`, `evt_start`, `evt_done` and `pix_req` are 0, and `status` is 0.
- R2: Each bus write has two phases, each lasting `cfg_div`+1 clock cycles. In the first phase `bus_wr_n` is 0; in the second it is 1. `bus_cs_n` is 0 and `bus_doe` is 1 through both phases, and `bus_dout` holds steady while `bus_wr_n` is 0. `bus_doe` is 0 when no job runs, and `bus_rd_n` stays 1.
- R3: A command write places the command byte in `bus_dout[7:0]`, with zeros above it, and has `bus_rs`=0. Parameter and pixel writes have `bus_rs`=1.
- R4: A `gen_trig` pulse with `gen_has_par`=0 produces exactly one command write of `gen_cmd`, and then the job ends with `bus_cs_n` released.
- R5: A `gen_trig` pulse with `gen_has_par`=1 sends the command and then holds `bus_cs_n` low. Each later `gen_trig` sends `gen_par` as one parameter write. The job ends when `gen_has_par` is 0 while no parameter is pending.
- R6: A `fill_trig` pulse sends command byte 0x2C and then `cfg_npix` pixel writes of the `fill_val` captured at the trigger. When `cfg_npix` is 0, only the command is sent.
- R7: A refresh sends command 0x2C and then, for each of `cfg_npix` pixels, raises `pix_req` and waits for a one-cycle `pix_ready` pulse. It then writes the `pix_data` present with that pulse. `refr_active` is 1 throughout the refresh job, and `pix_req` is never 1 while `refr_active` is 0.
- R8: Triggers of any kind that arrive while a job runs are ignored. The only exception is a `gen_trig` that supplies a parameter under R5.
- R9: When several job triggers arrive in the same idle cycle, generic beats fill, fill beats refresh, and refresh beats a timer expiry.
- R10: `evt_start` is a one-cycle pulse at the start of each job and `evt_done` is a one-cycle pulse at its end; the two never coincide. `status` is 0 when idle and nonzero while a job runs.
- R11: With `cfg_period` nonzero, the timer expires every `cfg_period` cycles and starts a refresh, so successive automatic refreshes start `cfg_period` cycles apart. An expiry during a running job is held and launched once the bus is idle. A `cfg_period` of 0 stops the timer.
- R12: With `cfg_sync_en`=1, a held expiry is launched only in a cycle where the timer count equals `cfg_sync_val`. If that value is never reached (`cfg_sync_val` ≥ `cfg_period`), no automatic refresh starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | 3 | Bus phase length minus one, in clock cycles |
| cfg_npix | input | 17 | Number of pixels per fill or refresh |
| cfg_period | input | 12 | Automatic refresh period in cycles, 0 disables |
| cfg_sync_en | input | 1 | Align automatic refresh to the sync point |
| cfg_sync_val | input | 10 | Timer count at which a held refresh may launch |
| gen_cmd | input | 8 | Generic command byte |
| gen_has_par | input | 1 | Parameters follow the generic command |
| gen_par | input | 16 | Parameter word for the next parameter trigger |
| gen_trig | input | 1 | Start a generic command or supply a parameter |
| fill_val | input | 16 | Fill word |
| fill_trig | input | 1 | Start a full-screen fill |
| refr_trig | input | 1 | Start a frame refresh |
| pix_data | input | 16 | Pixel word from the backend |
| pix_ready | input | 1 | Pixel word valid, one-cycle pulse |
| pix_req | output | 1 | Request for the next pixel word |
| refr_active | output | 1 | A refresh job is running |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_rd_n | output | 1 | Panel read strobe, active low |
| bus_wr_n | output | 1 | Panel write strobe, active low |
| bus_rs | output | 1 | Register select: 0 command, 1 parameter or data |
| bus_dout | output | 16 | Panel data output |
| bus_doe | output | 1 | Panel data output enable |
| evt_start | output | 1 | Job start pulse |
| evt_done | output | 1 | Job done pulse |
| status | output | 5 | Sequencer state code |

## Verification
The assertions assume that `cfg_div`, `cfg_npix` and the timer settings stay constant while a job runs. They also assume that `pix_ready` pulses for one cycle and only while `pix_req` is high. The stimulus changes configuration only between jobs, or while the timer is idle, and its backend model answers each request with a single pulse two cycles after it sees the request. Triggers are single-cycle pulses, driven on the falling clock edge.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int STATE_W = 5;

  typedef enum logic [STATE_W-1:0] {
    S_IDLE     = 5'd0,
    S_CMD_LO   = 5'd1,
    S_CMD_HI   = 5'd2,
    S_PAR_WAIT = 5'd3,
    S_PAR_LO   = 5'd4,
    S_PAR_HI   = 5'd5,
    S_PIX_WAIT = 5'd6,
    S_PIX_LO   = 5'd7,
    S_PIX_HI   = 5'd8,
    S_END      = 5'd9
  } seq_state_t;

  typedef enum logic [1:0] {
    J_GEN  = 2'd0,
    J_FILL = 2'd1,
    J_REF  = 2'd2
  } job_kind_t;

endpackage

// File: rtl/lcdc_phase_div.sv
module lcdc_phase_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == cfg_div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R2: within a bus phase the count never passes the configured length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= cfg_div));

endmodule

// File: rtl/lcdc_auto_refresh.sv
module lcdc_auto_refresh #(
  parameter int PER_W  = 12,
  parameter int SYNC_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic              cfg_sync_en,
  input  logic [SYNC_W-1:0] cfg_sync_val,
  input  logic              ack,
  output logic              go
);

  logic [PER_W-1:0] cnt;
  logic             pend;
  logic             wrap;

  assign wrap = (cfg_period != '0) && (cnt == cfg_period - PER_W'(1));
  assign go   = pend && (!cfg_sync_en || (cnt == PER_W'(cfg_sync_val)));

  always_ff @(posedge clk) begin
    if (rst || cfg_period == '0) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end

  // R11: an expiry is held until the sequencer takes it
  a_r11_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack && cfg_period != '0) |=> (pend || $past(cfg_period) == '0 || cfg_period == '0));

  // R11: a stopped timer holds nothing
  a_r11_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (cfg_period == '0) |=> !pend);

endmodule

// File: rtl/lcdc_seq.sv
module lcdc_seq
  import lcdc_pkg::*;
#(
  parameter int              PIX_W  = 17,
  parameter int              DATA_W = 16,
  parameter int              CMD_W  = 8,
  parameter logic [CMD_W-1:0] MW_OP = 8'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              gen_trig,
  input  logic [CMD_W-1:0]  gen_cmd,
  input  logic              gen_has_par,
  input  logic [DATA_W-1:0] gen_par,
  input  logic              fill_trig,
  input  logic [DATA_W-1:0] fill_val,
  input  logic              refr_trig,
  input  logic              auto_go,
  input  logic [PIX_W-1:0]  npix,
  input  logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  output seq_state_t        state,
  output job_kind_t         kind,
  output logic [DATA_W-1:0] word,
  output logic              run,
  output logic              launch,
  output logic              auto_ack
);

  localparam int PAD_W = DATA_W - CMD_W;

  seq_state_t        nxt;
  job_kind_t         kind_n;
  logic [DATA_W-1:0] word_n;
  logic [DATA_W-1:0] fill_q;
  logic [PIX_W-1:0]  cnt;
  logic              has_par_q;
  logic              ld_cnt, dec_cnt;

  assign run = (state == S_CMD_LO) || (state == S_CMD_HI) ||
               (state == S_PAR_LO) || (state == S_PAR_HI) ||
               (state == S_PIX_LO) || (state == S_PIX_HI);

  always_comb begin
    nxt      = state;
    kind_n   = kind;
    word_n   = word;
    launch   = 1'b0;
    auto_ack = 1'b0;
    ld_cnt   = 1'b0;
    dec_cnt  = 1'b0;
    case (state)
      S_IDLE: begin
        if (gen_trig) begin
          launch = 1'b1;
          kind_n = J_GEN;
          word_n = {{PAD_W{1'b0}}, gen_cmd};
          nxt    = S_CMD_LO;
        end else if (fill_trig) begin
          launch = 1'b1;
          kind_n = J_FILL;
          word_n = {{PAD_W{1'b0}}, MW_OP};
          ld_cnt = 1'b1;
          nxt    = S_CMD_LO;
        end else if (refr_trig || auto_go) begin
          launch   = 1'b1;
          auto_ack = auto_go;
          kind_n   = J_REF;
          word_n   = {{PAD_W{1'b0}}, MW_OP};
          ld_cnt   = 1'b1;
          nxt      = S_CMD_LO;
        end
      end
      S_CMD_LO: if (tick) nxt = S_CMD_HI;
      S_CMD_HI: begin
        if (tick) begin
          if (kind == J_GEN)       nxt = has_par_q ? S_PAR_WAIT : S_END;
          else if (cnt == '0)      nxt = S_END;
          else if (kind == J_FILL) begin
            word_n = fill_q;
            nxt    = S_PIX_LO;
          end else                 nxt = S_PIX_WAIT;
        end
      end
      S_PAR_WAIT: begin
        if (gen_trig) begin
          word_n = gen_par;
          nxt    = S_PAR_LO;
        end else if (!gen_has_par) begin
          nxt = S_END;
        end
      end
      S_PAR_LO: if (tick) nxt = S_PAR_HI;
      S_PAR_HI: if (tick) nxt = S_PAR_WAIT;
      S_PIX_WAIT: begin
        if (pix_ready) begin
          word_n = pix_data;
          nxt    = S_PIX_LO;
        end
      end
      S_PIX_LO: if (tick) nxt = S_PIX_HI;
      S_PIX_HI: begin
        if (tick) begin
          dec_cnt = 1'b1;
          if (cnt == PIX_W'(1))    nxt = S_END;
          else if (kind == J_FILL) begin
            word_n = fill_q;
            nxt    = S_PIX_LO;
          end else                 nxt = S_PIX_WAIT;
        end
      end
      S_END:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind      <= J_GEN;
      word      <= '0;
      fill_q    <= '0;
      cnt       <= '0;
      has_par_q <= 1'b0;
    end else begin
      state <= nxt;
      kind  <= kind_n;
      word  <= word_n;
      if (launch && gen_trig) has_par_q <= gen_has_par;
      if (launch && !gen_trig && fill_trig) fill_q <= fill_val;
      if (ld_cnt)       cnt <= npix;
      else if (dec_cnt) cnt <= cnt - 1'b1;
    end
  end

  // R7: a refresh waits for the backend before each pixel
  a_r7_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (state == S_PIX_WAIT && !pix_ready) |=> (state == S_PIX_WAIT));

  // R6: a pixel write is only issued while pixels remain
  a_r6_cnt_left: assert property (@(posedge clk) disable iff (rst)
    (state == S_PIX_LO) |-> (cnt != '0));

  // R8: a running job keeps its kind until it ends
  a_r8_kind_kept: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(kind));

endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
  import lcdc_pkg::*;
#(
  parameter int               DIV_W  = 3,
  parameter int               PER_W  = 12,
  parameter int               SYNC_W = 10,
  parameter int               PIX_W  = 17,
  parameter int               DATA_W = 16,
  parameter int               CMD_W  = 8,
  parameter logic [CMD_W-1:0] MW_OP  = 8'h2C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [PIX_W-1:0]    cfg_npix,
  input  logic [PER_W-1:0]    cfg_period,
  input  logic                cfg_sync_en,
  input  logic [SYNC_W-1:0]   cfg_sync_val,
  input  logic [CMD_W-1:0]    gen_cmd,
  input  logic                gen_has_par,
  input  logic [DATA_W-1:0]   gen_par,
  input  logic                gen_trig,
  input  logic [DATA_W-1:0]   fill_val,
  input  logic                fill_trig,
  input  logic                refr_trig,
  input  logic [DATA_W-1:0]   pix_data,
  input  logic                pix_ready,
  output logic                pix_req,
  output logic                refr_active,
  output logic                bus_cs_n,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic                bus_rs,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                bus_doe,
  output logic                evt_start,
  output logic                evt_done,
  output logic [STATE_W-1:0]  status
);

  seq_state_t        st;
  job_kind_t         kind;
  logic [DATA_W-1:0] word;
  logic              run, tick, launch, auto_ack, auto_go;
  logic              in_lo, in_hi, in_data;

  lcdc_phase_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(run), .cfg_div(cfg_div), .tick(tick)
  );

  lcdc_auto_refresh #(.PER_W(PER_W), .SYNC_W(SYNC_W)) u_timer (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_sync_en(cfg_sync_en),
    .cfg_sync_val(cfg_sync_val), .ack(auto_ack), .go(auto_go)
  );

  lcdc_seq #(.PIX_W(PIX_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .MW_OP(MW_OP)) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .gen_trig(gen_trig), .gen_cmd(gen_cmd), .gen_has_par(gen_has_par), .gen_par(gen_par),
    .fill_trig(fill_trig), .fill_val(fill_val), .refr_trig(refr_trig), .auto_go(auto_go),
    .npix(cfg_npix), .pix_ready(pix_ready), .pix_data(pix_data),
    .state(st), .kind(kind), .word(word), .run(run), .launch(launch), .auto_ack(auto_ack)
  );

  assign in_lo   = (st == S_CMD_LO) || (st == S_PAR_LO) || (st == S_PIX_LO);
  assign in_hi   = (st == S_CMD_HI) || (st == S_PAR_HI) || (st == S_PIX_HI);
  assign in_data = (st == S_PAR_LO) || (st == S_PAR_HI) ||
                   (st == S_PIX_LO) || (st == S_PIX_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_rs    <= 1'b0;
      bus_doe   <= 1'b0;
      bus_dout  <= '0;
      evt_start <= 1'b0;
    end else begin
      bus_cs_n  <= (st == S_IDLE) || (st == S_END);
      bus_wr_n  <= !in_lo;
      bus_rs    <= in_data;
      bus_doe   <= in_lo || in_hi;
      bus_dout  <= word;
      evt_start <= launch;
    end
  end

  assign bus_rd_n    = 1'b1;
  assign pix_req     = (st == S_PIX_WAIT);
  assign refr_active = (kind == J_REF) && (st != S_IDLE);
  assign evt_done    = (st == S_END);
  assign status      = st;

  // R2: strobe only inside a selected transfer
  a_r2_wr_in_cs: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> !bus_cs_n);

  // R2: data driven while the strobe is low
  a_r2_doe_wr: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_doe);

  // R2: data steady during the low phase
  a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_dout));

  // R10: start and done pulses never overlap
  a_r10_evt_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_start, evt_done}));

  // R7: pixel requests only inside a refresh
  a_r7_req_active: assert property (@(posedge clk) disable iff (rst)
    pix_req |-> refr_active);

endmodule

// File: tb/lcd_bus_ctrl_test.sv
`timescale 1ns/1ps
module lcd_bus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_div = '0;
  logic [16:0] cfg_npix = '0;
  logic [11:0] cfg_period = '0;
  logic        cfg_sync_en = 1'b0;
  logic [9:0]  cfg_sync_val = '0;
  logic [7:0]  gen_cmd = '0;
  logic        gen_has_par = 1'b0;
  logic [15:0] gen_par = '0;
  logic        gen_trig = 1'b0;
  logic [15:0] fill_val = '0;
  logic        fill_trig = 1'b0;
  logic        refr_trig = 1'b0;
  logic [15:0] pix_data = '0;
  logic        pix_ready = 1'b0;
  logic        pix_req, refr_active, bus_cs_n, bus_rd_n, bus_wr_n, bus_rs, bus_doe;
  logic        evt_start, evt_done;
  logic [15:0] bus_dout;
  logic [4:0]  status;

  lcd_bus_ctrl uut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_npix(cfg_npix), .cfg_period(cfg_period),
    .cfg_sync_en(cfg_sync_en), .cfg_sync_val(cfg_sync_val), .gen_cmd(gen_cmd),
    .gen_has_par(gen_has_par), .gen_par(gen_par), .gen_trig(gen_trig), .fill_val(fill_val),
    .fill_trig(fill_trig), .refr_trig(refr_trig), .pix_data(pix_data), .pix_ready(pix_ready),
    .pix_req(pix_req), .refr_active(refr_active), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_rs(bus_rs), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .evt_start(evt_start), .evt_done(evt_done), .status(status)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int wr_cnt = 0, start_cnt = 0, done_cnt = 0, cyc = 0;
  int lo_len = 0, hi_len = 0, exp_div = 0;
  bit hi_valid = 0, chk_hi = 0, sb_on = 1, prev_wr = 1, prev_start = 0, prev_done = 0;
  bit saw_req = 0;
  logic [16:0] cap;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] next_pix = 16'hA000;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic rs, input logic [15:0] d, input string rq);
    exp_q.push_back({rs, d});
    tag_q.push_back(rq);
  endtask

  always @(posedge clk) cyc++;

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [16:0] e;
    string t;
    if (!rst) begin
      if (prev_wr && !bus_wr_n) begin
        cap = {bus_rs, bus_dout};
        if (chk_hi && hi_valid) chk(hi_len == exp_div + 1, "R2", "high phase length", hi_len, exp_div + 1);
        lo_len = 1;
        hi_valid = 0;
      end else if (!prev_wr && !bus_wr_n) begin
        lo_len++;
      end else if (!prev_wr && bus_wr_n) begin
        chk(lo_len == exp_div + 1, "R2", "low phase length", lo_len, exp_div + 1);
        wr_cnt++;
        if (sb_on) begin
          if (exp_q.size() == 0) chk(0, "R8", "unexpected bus write", int'(cap), 0);
          else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cap == e, t, "bus write {rs,data}", int'(cap), int'(e));
          end
        end
        hi_len = 1;
        hi_valid = 1;
      end else if (hi_valid) begin
        hi_len++;
      end
      if (!bus_wr_n) chk(bus_doe && !bus_cs_n, "R2", "doe/cs during low phase", {bus_doe, bus_cs_n}, 2);
      if (bus_cs_n) hi_valid = 0;
      if (pix_req) begin
        saw_req = 1;
        chk(refr_active, "R7", "refr_active while pix_req", refr_active, 1);
      end
      if (evt_start) begin
        start_cnt++;
        chk(!prev_start, "R10", "evt_start width", 2, 1);
      end
      if (evt_done) begin
        done_cnt++;
        chk(!prev_done, "R10", "evt_done width", 2, 1);
      end
      prev_start = evt_start;
      prev_done  = evt_done;
      prev_wr    = bus_wr_n;
    end
  end

  // backend model: answers each request two cycles later with one pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && pix_req) begin
        repeat (2) @(negedge clk);
        pix_data  = next_pix;
        pix_ready = 1'b1;
        @(negedge clk);
        pix_ready = 1'b0;
        next_pix  = next_pix + 16'd1;
      end
    end
  end

  task automatic trig(input bit g, input bit f, input bit r);
    @(negedge clk);
    gen_trig = g; fill_trig = f; refr_trig = r;
    @(negedge clk);
    gen_trig = 0; fill_trig = 0; refr_trig = 0;
  endtask

  task automatic wait_done();
    int d;
    d = done_cnt;
    while (done_cnt == d) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_wr();
    int w;
    w = wr_cnt;
    while (wr_cnt == w) @(negedge clk);
  endtask

  task automatic check_idle(input string rq);
    chk(bus_cs_n && bus_wr_n && !bus_doe, rq, "bus idle {cs_n,wr_n,doe}",
        {bus_cs_n, bus_wr_n, bus_doe}, 3'b110);
    chk(status == 0, "R10", "status idle", status, 0);
    chk(exp_q.size() == 0, rq, "expected writes left", exp_q.size(), 0);
  endtask

  task automatic run_fill(input logic [15:0] v, input int n, input int dv, input string rq);
    int s;
    cfg_div = 3'(dv); exp_div = dv; cfg_npix = 17'(n); fill_val = v; chk_hi = 1;
    push_exp(1'b0, 16'h002C, "R3");
    for (int k = 0; k < n; k++) push_exp(1'b1, v, rq);
    s = start_cnt;
    trig(0, 1, 0);
    wait_done();
    chk(start_cnt - s == 1, "R10", "one start per fill", start_cnt - s, 1);
    check_idle(rq);
    chk_hi = 0;
  endtask

  task automatic measure_gaps(input string rq, input int per);
    int t0;
    while (!evt_start) @(negedge clk);
    @(negedge clk);
    while (!evt_start) @(negedge clk);
    chk(refr_active, rq, "automatic job is a refresh", refr_active, 1);
    t0 = cyc;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      while (!evt_start) @(negedge clk);
      chk(cyc - t0 == per, rq, "automatic refresh spacing", cyc - t0, per);
      t0 = cyc;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int s, d;
    repeat (4) @(negedge clk);
    chk(bus_cs_n && bus_wr_n && bus_rd_n && !bus_doe, "R1", "strobes in reset",
        {bus_cs_n, bus_wr_n, bus_rd_n, bus_doe}, 4'b1110);
    rst = 1'b0;
    @(negedge clk);
    chk(!evt_start && !evt_done && !pix_req && status == 0 && bus_cs_n, "R1", "state after reset",
        {evt_start, evt_done, pix_req, bus_cs_n, status}, 9'b000100000);

    // R4: bare generic command
    exp_div = 0; cfg_div = 0;
    gen_cmd = 8'h11; gen_has_par = 0;
    push_exp(1'b0, 16'h0011, "R4");
    s = start_cnt; d = done_cnt;
    trig(1, 0, 0);
    wait_done();
    chk(start_cnt - s == 1 && done_cnt - d == 1, "R10", "start/done pulses for R4 job",
        (start_cnt - s) * 16 + (done_cnt - d), 17);
    check_idle("R4");
    chk(bus_rd_n, "R2", "read strobe held high", bus_rd_n, 1);

    // R5: generic command with two streamed parameters
    exp_div = 2; cfg_div = 2;
    gen_cmd = 8'h2A; gen_has_par = 1;
    push_exp(1'b0, 16'h002A, "R3");
    trig(1, 0, 0);
    wait_wr();
    repeat (8) @(negedge clk);
    chk(!bus_cs_n && status != 0, "R5", "job held open for parameters", {bus_cs_n, status != 0}, 1);
    gen_par = 16'h0000;
    push_exp(1'b1, 16'h0000, "R5");
    trig(1, 0, 0);
    wait_wr();
    repeat (8) @(negedge clk);
    gen_par = 16'h013F;
    push_exp(1'b1, 16'h013F, "R5");
    trig(1, 0, 0);
    wait_wr();
    repeat (8) @(negedge clk);
    chk(!bus_cs_n, "R5", "still selected while more parameters allowed", bus_cs_n, 0);
    gen_has_par = 0;
    wait_done();
    check_idle("R5");

    // R6: fills with different lengths and bus speeds
    run_fill(16'hF800, 5, 0, "R6");
    run_fill(16'h07E0, 3, 3, "R2");
    run_fill(16'h1234, 0, 1, "R6");

    // R7: refresh fed by the backend
    cfg_div = 1; exp_div = 1; cfg_npix = 4; saw_req = 0;
    push_exp(1'b0, 16'h002C, "R3");
    for (int k = 0; k < 4; k++) push_exp(1'b1, next_pix + 16'(k), "R7");
    trig(0, 0, 1);
    @(negedge clk);
    chk(refr_active, "R7", "refr_active at refresh start", refr_active, 1);
    wait_done();
    chk(saw_req, "R7", "pixel request seen", saw_req, 1);
    chk(!refr_active && !pix_req, "R7", "refresh flags clear after job", {refr_active, pix_req}, 0);
    check_idle("R7");

    // R8: triggers while busy are ignored
    cfg_div = 0; exp_div = 0; cfg_npix = 6; fill_val = 16'h5A5A; gen_cmd = 8'h01;
    push_exp(1'b0, 16'h002C, "R3");
    for (int k = 0; k < 6; k++) push_exp(1'b1, 16'h5A5A, "R8");
    s = start_cnt;
    trig(0, 1, 0);
    repeat (3) @(negedge clk);
    trig(1, 0, 1);
    trig(0, 1, 0);
    wait_done();
    repeat (10) @(negedge clk);
    chk(start_cnt - s == 1, "R8", "busy triggers start nothing", start_cnt - s, 1);
    check_idle("R8");

    // R9: priorities of simultaneous triggers
    gen_cmd = 8'h29; gen_has_par = 0;
    push_exp(1'b0, 16'h0029, "R9");
    s = start_cnt;
    trig(1, 1, 1);
    wait_done();
    repeat (10) @(negedge clk);
    chk(start_cnt - s == 1, "R9", "generic wins, one job", start_cnt - s, 1);
    check_idle("R9");
    cfg_npix = 2; fill_val = 16'hBEEF;
    push_exp(1'b0, 16'h002C, "R9");
    push_exp(1'b1, 16'hBEEF, "R9");
    push_exp(1'b1, 16'hBEEF, "R9");
    s = start_cnt;
    trig(0, 1, 1);
    wait_done();
    repeat (10) @(negedge clk);
    chk(start_cnt - s == 1, "R9", "fill wins over refresh", start_cnt - s, 1);
    check_idle("R9");

    // R11: periodic automatic refresh
    sb_on = 0; cfg_npix = 1; cfg_div = 0; exp_div = 0;
    cfg_period = 12'd40;
    measure_gaps("R11", 40);

    // R12: synchronised launch, then an unreachable sync point
    cfg_sync_val = 10'd7; cfg_sync_en = 1;
    measure_gaps("R12", 40);
    cfg_sync_val = 10'd100;
    repeat (60) @(negedge clk);
    s = start_cnt;
    repeat (300) @(negedge clk);
    chk(start_cnt - s == 0, "R12", "no launch with unreachable sync point", start_cnt - s, 0);
    cfg_period = 0; cfg_sync_en = 0;
    repeat (5) @(negedge clk);
    s = start_cnt;
    repeat (100) @(negedge clk);
    chk(start_cnt - s == 0, "R11", "period 0 stops the timer", start_cnt - s, 0);

    // R11: expiry during a long fill waits for idle
    cfg_npix = 30; fill_val = 16'h0F0F;
    s = start_cnt;
    @(negedge clk);
    cfg_period = 12'd20;
    trig(0, 1, 0);
    d = done_cnt;
    while (done_cnt == d) @(negedge clk);
    chk(start_cnt - s == 1, "R11", "no start during fill", start_cnt - s, 1);
    repeat (3) @(negedge clk);
    chk(start_cnt - s == 2 && refr_active, "R11", "held refresh launched after fill",
        (start_cnt - s) * 2 + refr_active, 5);
    cfg_period = 0;
    wait_done();
    repeat (5) @(negedge clk);
    check_idle("R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule